// File: doc/BRIEF.md
# Two-Level Debug Breakpoint Trigger Controller

This block sequences a debug breakpoint trigger through up to two chained levels and keeps a readable 4-bit status of where the sequence stands. Software programs a trigger definition holding a level-1 enable, a level-2 enable and a 2-bit response code. Match strobes arrive per level from two sources: program-counter comparators, which are precise, and bus address/data comparators, which are imprecise. The block also drives a 4-bit debug-data code that mirrors the status.

When the last enabled level matches, the block acts on the response code. It either asks the core to halt, or it raises a debug interrupt. That interrupt outranks the level-7 interrupt, is taken only at a per-instruction sample point, and carries a fixed exception vector. Taking it puts the core in emulator mode. While that mode is active the processor-status output shows a dedicated code for a fixed number of cycles, and every interrupt is ignored. A return strobe leaves emulator mode and ends a halt.

The control and status pins are plain level or strobe signals. No data stream passes through the block, so it has no valid/ready interface.

Top module: `bkpt_trig_ctrl`

## Requirements
- R1: `bp_status` only ever holds one of five codes: 0000 no breakpoint enabled, 0001 waiting for level 1, 0010 level 1 triggered, 0101 waiting for level 2, 0110 level 2 triggered. Reset gives 0000.
- R2: `ddata` is 0000, 0010, 0100, 1010 or 1100 when `bp_status` is 0000, 0001, 0010, 0101 or 0110 respectively.
- R3: A `cfg_wr` pulse clears the status. On the next cycle `bp_status` is 0001 if the new level-1 enable is set and 0000 otherwise, and any pending debug interrupt is dropped.
- R4: In state 0001, a level-1 match (PC or bus) moves the status to 0010 if level 2 is disabled, or to 0101 if it is enabled. In state 0101, a level-2 match moves the status to 0110. A match for the level that is not awaited changes nothing.
- R5: A `csr_rd` pulse clears the status to 0000 when it reads 0110, or when it reads 0010 with level 2 disabled. In every other state the read leaves the status unchanged. A write in the same cycle takes priority.
- R6: With response 01, a completed trigger sets `halt_req` on the next cycle. While `halt_req` is high, `pst` shows 0xF.
- R7: With response 10, a trigger completed by a PC match in a `sample_pt` cycle is taken in that same cycle (precise). A trigger completed by a bus match sets `dbg_pend`, and the interrupt is taken at the next `sample_pt`. `dbg_take` is a single-cycle pulse, and `dbg_vector` shows 12 in that cycle and 0 otherwise.
- R8: A debug interrupt is taken in preference to a level-7 request in the same sample point. `irq7_take` = `sample_pt` & `irq7_req` & no emulator mode & no debug take.
- R9: After a take, `emu_mode` is 1. `pst` shows 0xD for exactly PST_D_CYCLES (3) cycles and then `pst_norm`, unless a halt overrides it. While in emulator mode, neither `dbg_take` nor `irq7_take` is asserted, and completions set no pending request.
- R10: `emu_ret` clears `emu_mode` and `halt_req` on the next cycle and ends any 0xD display, so `pst` returns to `pst_norm`.
- R11: Response codes 00 and 11 produce no halt, no pending interrupt and no take, while the status still advances on matches as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Trigger-definition write strobe |
| cfg_l1_en | input | 1 | Level-1 enable written with cfg_wr |
| cfg_l2_en | input | 1 | Level-2 enable written with cfg_wr |
| cfg_resp | input | 2 | Response code: 01 halt, 10 debug interrupt, 00/11 none |
| csr_rd | input | 1 | Status read strobe (read-to-clear rule) |
| pc_hit_l1 | input | 1 | PC comparator match, level 1 |
| pc_hit_l2 | input | 1 | PC comparator match, level 2 |
| bus_hit_l1 | input | 1 | Bus address/data comparator match, level 1 |
| bus_hit_l2 | input | 1 | Bus address/data comparator match, level 2 |
| sample_pt | input | 1 | Per-instruction interrupt sample point |
| irq7_req | input | 1 | Level-7 interrupt request |
| emu_ret | input | 1 | Return-from-emulator strobe |
| pst_norm | input | 4 | Processor-status code during normal execution |
| bp_status | output | 4 | Breakpoint status field |
| ddata | output | 4 | Debug data code for the status |
| halt_req | output | 1 | Halt request to the core |
| dbg_pend | output | 1 | Debug interrupt pending |
| emu_mode | output | 1 | Emulator mode active |
| dbg_take | output | 1 | Debug interrupt taken this cycle |
| dbg_vector | output | 8 | Exception vector during dbg_take |
| irq7_take | output | 1 | Level-7 interrupt taken this cycle |
| pst | output | 4 | Processor-status output |

## Verification
The assertions assume that a PC match is strobed only in the `sample_pt` cycle of its target instruction, since that is what makes the precise take possible. They also assume that `emu_ret` is pulsed only to end a halt or emulator mode. The bench respects both assumptions: every PC-sourced match is driven together with `sample_pt`, and bus matches are driven with or without a sample point. The sweep covers every enable/response combination with both match sources, and it orders each run so that the return strobe comes last. Level-7 requests are offered at sample points inside and outside emulator mode, so priority and masking are both seen.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic [3:0] {
    ST_OFF = 4'b0000,
    ST_W1  = 4'b0001,
    ST_T1  = 4'b0010,
    ST_W2  = 4'b0101,
    ST_T2  = 4'b0110
  } bstat_e;

  typedef enum logic [1:0] {
    RSP_NONE0 = 2'b00,
    RSP_HALT  = 2'b01,
    RSP_IRQ   = 2'b10,
    RSP_NONE3 = 2'b11
  } resp_e;

  localparam logic [3:0] PST_HALT_CODE = 4'hF;
  localparam logic [3:0] PST_DBG_CODE  = 4'hD;
endpackage

// File: rtl/bkpt_seq.sv
module bkpt_seq
  import bkpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       cfg_l1_en,
  input  logic       cfg_l2_en,
  input  logic [1:0] cfg_resp,
  input  logic       csr_rd,
  input  logic       pc_l1,
  input  logic       pc_l2,
  input  logic       bus_l1,
  input  logic       bus_l2,
  output bstat_e     status,
  output resp_e      resp_q,
  output logic       done,
  output logic       done_pc
);
  bstat_e st_q, st_d;
  logic   l2_en_q;
  logic   l1_hit, l2_hit, done_l1, adv_l2, done_l2, rd_clr;

  assign l1_hit  = pc_l1 | bus_l1;
  assign l2_hit  = pc_l2 | bus_l2;
  assign done_l1 = !cfg_wr && (st_q == ST_W1) && l1_hit && !l2_en_q;
  assign adv_l2  = !cfg_wr && (st_q == ST_W1) && l1_hit && l2_en_q;
  assign done_l2 = !cfg_wr && (st_q == ST_W2) && l2_hit;
  assign rd_clr  = csr_rd && ((st_q == ST_T2) || ((st_q == ST_T1) && !l2_en_q));

  assign done    = done_l1 | done_l2;
  assign done_pc = (done_l1 & pc_l1) | (done_l2 & pc_l2);
  assign status  = st_q;

  always_comb begin
    st_d = st_q;
    if (cfg_wr)       st_d = cfg_l1_en ? ST_W1 : ST_OFF;
    else if (rd_clr)  st_d = ST_OFF;
    else if (done_l1) st_d = ST_T1;
    else if (adv_l2)  st_d = ST_W2;
    else if (done_l2) st_d = ST_T2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      l2_en_q <= 1'b0;
      resp_q  <= RSP_NONE0;
    end else begin
      st_q <= st_d;
      if (cfg_wr) begin
        l2_en_q <= cfg_l2_en;
        resp_q  <= resp_e'(cfg_resp);
      end
    end
  end
endmodule

// File: rtl/bkpt_resp.sv
module bkpt_resp
  import bkpt_pkg::*;
#(
  parameter int PST_D_CYCLES = 3,
  parameter int VECTOR       = 12,
  parameter int VEC_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  resp_e            resp,
  input  logic             done,
  input  logic             done_pc,
  input  logic             sample_pt,
  input  logic             irq7_req,
  input  logic             emu_ret,
  input  logic [3:0]       pst_norm,
  output logic             halt_req,
  output logic             dbg_pend,
  output logic             emu_mode,
  output logic             dbg_take,
  output logic [VEC_W-1:0] dbg_vector,
  output logic             irq7_take,
  output logic [3:0]       pst
);
  localparam int CNT_W = (PST_D_CYCLES < 2) ? 1 : $clog2(PST_D_CYCLES + 1);

  logic             pend_q, emu_q, halt_q;
  logic [CNT_W-1:0] dcnt_q;
  logic             is_irq, is_halt;

  assign is_irq  = (resp == RSP_IRQ);
  assign is_halt = (resp == RSP_HALT);

  assign dbg_take   = sample_pt && !emu_q && is_irq && (pend_q || done_pc);
  assign irq7_take  = sample_pt && irq7_req && !emu_q && !dbg_take;
  assign dbg_vector = dbg_take ? VEC_W'(VECTOR) : '0;

  assign halt_req = halt_q;
  assign dbg_pend = pend_q;
  assign emu_mode = emu_q;

  always_comb begin
    if (halt_q)                pst = PST_HALT_CODE;
    else if (dcnt_q != '0)     pst = PST_DBG_CODE;
    else                       pst = pst_norm;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      emu_q  <= 1'b0;
      halt_q <= 1'b0;
      dcnt_q <= '0;
    end else begin
      pend_q <= (pend_q || (done && is_irq && !emu_q)) && !dbg_take && !cfg_wr;
      emu_q  <= dbg_take || (emu_q && !emu_ret);
      halt_q <= (halt_q && !emu_ret) || (done && is_halt);
      if (dbg_take)            dcnt_q <= CNT_W'(PST_D_CYCLES);
      else if (emu_ret)        dcnt_q <= '0;
      else if (dcnt_q != '0)   dcnt_q <= dcnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/bkpt_ddmap.sv
module bkpt_ddmap
  import bkpt_pkg::*;
(
  input  bstat_e     status,
  output logic [3:0] ddata
);
  always_comb begin
    unique case (status)
      ST_W1:   ddata = 4'b0010;
      ST_T1:   ddata = 4'b0100;
      ST_W2:   ddata = 4'b1010;
      ST_T2:   ddata = 4'b1100;
      default: ddata = 4'b0000;
    endcase
  end
endmodule

// File: rtl/bkpt_trig_ctrl.sv
module bkpt_trig_ctrl
  import bkpt_pkg::*;
#(
  parameter int PST_D_CYCLES = 3,
  parameter int VECTOR       = 12,
  parameter int VEC_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_l1_en,
  input  logic             cfg_l2_en,
  input  logic [1:0]       cfg_resp,
  input  logic             csr_rd,
  input  logic             pc_hit_l1,
  input  logic             pc_hit_l2,
  input  logic             bus_hit_l1,
  input  logic             bus_hit_l2,
  input  logic             sample_pt,
  input  logic             irq7_req,
  input  logic             emu_ret,
  input  logic [3:0]       pst_norm,
  output logic [3:0]       bp_status,
  output logic [3:0]       ddata,
  output logic             halt_req,
  output logic             dbg_pend,
  output logic             emu_mode,
  output logic             dbg_take,
  output logic [VEC_W-1:0] dbg_vector,
  output logic             irq7_take,
  output logic [3:0]       pst
);
  bstat_e status;
  resp_e  resp_q;
  logic   done, done_pc;

  bkpt_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_l1_en (cfg_l1_en),
    .cfg_l2_en (cfg_l2_en),
    .cfg_resp  (cfg_resp),
    .csr_rd    (csr_rd),
    .pc_l1     (pc_hit_l1),
    .pc_l2     (pc_hit_l2),
    .bus_l1    (bus_hit_l1),
    .bus_l2    (bus_hit_l2),
    .status    (status),
    .resp_q    (resp_q),
    .done      (done),
    .done_pc   (done_pc)
  );

  bkpt_resp #(
    .PST_D_CYCLES (PST_D_CYCLES),
    .VECTOR       (VECTOR),
    .VEC_W        (VEC_W)
  ) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .resp       (resp_q),
    .done       (done),
    .done_pc    (done_pc),
    .sample_pt  (sample_pt),
    .irq7_req   (irq7_req),
    .emu_ret    (emu_ret),
    .pst_norm   (pst_norm),
    .halt_req   (halt_req),
    .dbg_pend   (dbg_pend),
    .emu_mode   (emu_mode),
    .dbg_take   (dbg_take),
    .dbg_vector (dbg_vector),
    .irq7_take  (irq7_take),
    .pst        (pst)
  );

  bkpt_ddmap u_map (
    .status (status),
    .ddata  (ddata)
  );

  assign bp_status = status;
endmodule

// File: rtl/bkpt_trig_chk.sv
module bkpt_trig_chk #(
  parameter int VECTOR = 12,
  parameter int VEC_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             cfg_l1_en,
  input logic [1:0]       cfg_resp,
  input logic             csr_rd,
  input logic             sample_pt,
  input logic             irq7_req,
  input logic             emu_ret,
  input logic [3:0]       pst_norm,
  input logic [3:0]       bp_status,
  input logic [3:0]       ddata,
  input logic             halt_req,
  input logic             dbg_pend,
  input logic             emu_mode,
  input logic             dbg_take,
  input logic [VEC_W-1:0] dbg_vector,
  input logic             irq7_take,
  input logic [3:0]       pst
);
  logic [1:0] resp_shadow;
  logic       resp_off;

  always_ff @(posedge clk) begin
    if (!rst_n)      resp_shadow <= 2'b00;
    else if (cfg_wr) resp_shadow <= cfg_resp;
  end
  assign resp_off = (resp_shadow == 2'b00) || (resp_shadow == 2'b11);

  a_r1_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bp_status inside {4'b0000, 4'b0001, 4'b0010, 4'b0101, 4'b0110});

  a_r2_ddata_map: assert property (@(posedge clk) disable iff (!rst_n)
    ddata == {bp_status[2:0], 1'b0});

  a_r3_write_arms: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (bp_status == ($past(cfg_l1_en) ? 4'b0001 : 4'b0000)) && !dbg_pend);

  a_r5_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && !cfg_wr && bp_status == 4'b0110) |=> bp_status == 4'b0000);

  a_r6_halt_pst: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> pst == 4'hF);

  a_r7_take_vector: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_take |-> sample_pt && dbg_vector == VEC_W'(VECTOR));

  a_r7_take_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_take |=> !dbg_take);

  a_r8_dbg_over_irq7: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_take |-> !irq7_take);

  a_r9_emu_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    emu_mode |-> !dbg_take && !irq7_take);

  a_r9_enter_emu: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_take |=> emu_mode && (halt_req || pst == 4'hD));

  a_r10_return: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_ret && !dbg_take) |=> !emu_mode && (halt_req || pst == pst_norm));

  a_r11_no_irq_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    resp_off |-> !dbg_pend && !dbg_take);

  a_r8_irq7_grant: assert property (@(posedge clk) disable iff (!rst_n)
    irq7_take |-> sample_pt && irq7_req);
endmodule

bind bkpt_trig_ctrl bkpt_trig_chk #(.VECTOR(VECTOR), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_l1_en  (cfg_l1_en),
  .cfg_resp   (cfg_resp),
  .csr_rd     (csr_rd),
  .sample_pt  (sample_pt),
  .irq7_req   (irq7_req),
  .emu_ret    (emu_ret),
  .pst_norm   (pst_norm),
  .bp_status  (bp_status),
  .ddata      (ddata),
  .halt_req   (halt_req),
  .dbg_pend   (dbg_pend),
  .emu_mode   (emu_mode),
  .dbg_take   (dbg_take),
  .dbg_vector (dbg_vector),
  .irq7_take  (irq7_take),
  .pst        (pst)
);

// File: tb/bkpt_trig_ctrl_test.sv
module bkpt_trig_ctrl_test;
  localparam int NDWELL = 3;
  localparam logic [3:0] NORM = 4'h1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_l1_en = 0, cfg_l2_en = 0;
  logic [1:0] cfg_resp = 2'b00;
  logic csr_rd = 0, pc_hit_l1 = 0, pc_hit_l2 = 0, bus_hit_l1 = 0, bus_hit_l2 = 0;
  logic sample_pt = 0, irq7_req = 0, emu_ret = 0;
  logic [3:0] pst_norm = NORM;
  logic [3:0] bp_status, ddata, pst;
  logic halt_req, dbg_pend, emu_mode, dbg_take, irq7_take;
  logic [7:0] dbg_vector;

  int n_checks = 0, n_errors = 0;
  bit finished = 0;

  // bench model state
  int mst = 0, mcnt = 0;
  bit ml2 = 0, memu = 0, mhalt = 0, mpend = 0;
  int mresp = 0;

  always #10 clk = ~clk;

  bkpt_trig_ctrl #(.PST_D_CYCLES(NDWELL)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_l1_en(cfg_l1_en),
    .cfg_l2_en(cfg_l2_en), .cfg_resp(cfg_resp), .csr_rd(csr_rd),
    .pc_hit_l1(pc_hit_l1), .pc_hit_l2(pc_hit_l2), .bus_hit_l1(bus_hit_l1),
    .bus_hit_l2(bus_hit_l2), .sample_pt(sample_pt), .irq7_req(irq7_req),
    .emu_ret(emu_ret), .pst_norm(pst_norm), .bp_status(bp_status),
    .ddata(ddata), .halt_req(halt_req), .dbg_pend(dbg_pend),
    .emu_mode(emu_mode), .dbg_take(dbg_take), .dbg_vector(dbg_vector),
    .irq7_take(irq7_take), .pst(pst));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_inputs();
    cfg_wr = 0; csr_rd = 0; pc_hit_l1 = 0; pc_hit_l2 = 0; bus_hit_l1 = 0;
    bus_hit_l2 = 0; sample_pt = 0; irq7_req = 0; emu_ret = 0;
  endtask

  task automatic check_regs();
    int exp_pst;
    chk(mst == 0 || mst == 1 || mst == 2 || mst == 5 || mst == 6, "R1 model", mst, 0);
    chk(bp_status == 4'(mst), "R4 status", bp_status, mst);
    chk(ddata == 4'(mst << 1), "R2 ddata", ddata, mst << 1);
    chk(halt_req == mhalt, (mresp == 1) ? "R6 halt_req" : "R11 halt_req", halt_req, mhalt);
    chk(dbg_pend == mpend, (mresp == 2) ? "R7 dbg_pend" : "R11 dbg_pend", dbg_pend, mpend);
    chk(emu_mode == memu, "R9 emu_mode", emu_mode, memu);
    exp_pst = mhalt ? 15 : (mcnt != 0 ? 13 : int'(NORM));
    chk(pst == 4'(exp_pst), "R9 pst", pst, exp_pst);
  endtask

  task automatic cfg(input bit l1, input bit l2, input int rsp);
    clear_inputs();
    cfg_wr = 1; cfg_l1_en = l1; cfg_l2_en = l2; cfg_resp = 2'(rsp);
    @(posedge clk); @(negedge clk);
    clear_inputs();
    mst = l1 ? 1 : 0; ml2 = l2; mresp = rsp; mpend = 0;
    if (mcnt != 0) mcnt--;
    chk(bp_status == 4'(mst), "R3 write status", bp_status, mst);
    chk(dbg_pend == 1'b0, "R3 write drops pending", dbg_pend, 0);
  endtask

  task automatic step(input bit l1h, input bit l2h, input bit pc, input bit samp,
                      input bit rd, input bit ret, input bit i7);
    bit done, take_e, i7_e;
    int nst;
    pc_hit_l1 = l1h & pc;  bus_hit_l1 = l1h & !pc;
    pc_hit_l2 = l2h & pc;  bus_hit_l2 = l2h & !pc;
    sample_pt = samp; csr_rd = rd; emu_ret = ret; irq7_req = i7;
    #2;
    done   = (mst == 1 && l1h && !ml2) || (mst == 5 && l2h);
    take_e = samp && !memu && mresp == 2 && (mpend || (done && pc));
    i7_e   = samp && i7 && !memu && !take_e;
    chk(dbg_take == take_e, pc ? "R7 precise take" : "R7 take", dbg_take, take_e);
    chk(dbg_vector == (take_e ? 8'd12 : 8'd0), "R7 vector", dbg_vector, take_e ? 12 : 0);
    chk(irq7_take == i7_e, "R8 irq7_take", irq7_take, i7_e);
    nst = mst;
    if (rd && (mst == 6 || (mst == 2 && !ml2))) nst = 0;
    else if (mst == 1 && l1h) nst = ml2 ? 5 : 2;
    else if (mst == 5 && l2h) nst = 6;
    @(posedge clk); @(negedge clk);
    clear_inputs();
    mpend = (mpend || (done && mresp == 2 && !memu)) && !take_e;
    mhalt = (mhalt && !ret) || (done && mresp == 1);
    if (take_e) mcnt = NDWELL; else if (ret) mcnt = 0; else if (mcnt != 0) mcnt--;
    memu = take_e || (memu && !ret);
    if (rd) chk(bp_status == 4'(nst), "R5 read-to-clear", bp_status, nst);
    if (ret) chk(!emu_mode && !halt_req, "R10 return", {emu_mode, halt_req}, 0);
    mst = nst;
    check_regs();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bp_status == 4'b0000, "R1 reset status", bp_status, 0);
    chk(ddata == 4'b0000, "R2 reset ddata", ddata, 0);
    chk(!halt_req && !dbg_pend && !emu_mode, "R9 reset flags", {halt_req, dbg_pend, emu_mode}, 0);
    chk(pst == NORM, "R10 reset pst", pst, NORM);

    for (int l1 = 0; l1 < 2; l1++)
      for (int l2 = 0; l2 < 2; l2++)
        for (int rsp = 0; rsp < 4; rsp++)
          for (int p = 0; p < 2; p++) begin
            cfg(l1[0], l2[0], rsp);
            step(0, 1, p[0], p[0], 0, 0, 0);   // wrong level first: ignored
            step(0, 0, 0, 0, 1, 0, 0);         // read while waiting
            step(1, 0, p[0], p[0], 0, 0, 0);   // level-1 match
            step(0, 0, 0, 1, 0, 0, 1);         // sample point with irq7
            step(0, 1, p[0], p[0], 0, 0, 0);   // level-2 match
            step(0, 0, 0, 1, 0, 0, 1);
            for (int k = 0; k < NDWELL + 1; k++) step(0, 0, 0, 0, 0, 0, 0);
            step(0, 0, 0, 1, 0, 0, 1);         // irq7 while in emulator mode
            step(0, 0, 0, 0, 1, 0, 0);         // read
            step(0, 0, 0, 0, 1, 0, 0);         // second read
            step(0, 0, 0, 0, 0, 1, 0);         // return strobe
            step(0, 0, 0, 1, 0, 0, 1);         // irq7 after return
          end

    // write during the wait for level 2 re-arms the sequence (R3)
    cfg(1, 1, 2);
    step(1, 0, 0, 0, 0, 0, 0);
    cfg(1, 0, 2);
    step(1, 0, 0, 0, 0, 0, 0);                 // bus match -> pending
    cfg(0, 0, 2);                              // write drops pending (R3)
    step(0, 0, 0, 1, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule